// File: doc/BRIEF.md
# Per-Digit Carry/Borrow Adder

This block adds or subtracts two 32-bit operands in a single combinational path. Next to the sum and a signed-overflow flag, it produces one status bit for each 4-bit digit of the datapath. After an add, a digit's bit holds the carry that left that digit. After a subtract, it holds the inverted borrow, so a 1 means no borrow was taken from that digit. Software that does decimal or digit-wise arithmetic reads this vector from a status word. Decimal correction and the status word itself sit outside the block.

Subtraction is formed as A + ~B + carry-in. A plain subtract therefore drives carry-in high, and each digit carry already carries the no-borrow sense. A trapping variant raises a trap request when the operation overflows. In that case the digit vector is not written. Otherwise the vector is written on the clock edge at which the write enable is high, and it holds its value at all other times.

Top module: `cb_digit_adder`

## Requirements
- R1: With `sub_sel` = 0, `result` equals `opnd_a + opnd_b + carry_in` modulo 2^32, in the same cycle.
- R2: With `sub_sel` = 1, `result` equals `opnd_a + ~opnd_b + carry_in` modulo 2^32, in the same cycle. With `carry_in` = 1 this is `opnd_a - opnd_b`.
- R3: After a committed add, bit k of `digit_cb` (k = 0..7, bit 7 for bits 31:28, bit 0 for bits 3:0) is 1 exactly when a carry left digit k. The value is visible the cycle after the write edge.
- R4: After a committed subtract, bit k of `digit_cb` is 0 when a borrow was taken from digit k and 1 otherwise. This is the carry out of digit k of `opnd_a + ~opnd_b + carry_in`.
- R5: `ovf` is 1, in the same cycle, exactly when the two's-complement result overflows. That means the effective operands share a sign and the result's sign differs from it.
- R6: `trap_req` equals `trap_var` AND `ovf`, in the same cycle.
- R7: When `wr_en` is 1 and `trap_req` is 1, `digit_cb` keeps its previous value.
- R8: When `wr_en` is 0, `digit_cb` keeps its previous value, whatever the operands are.
- R9: When `trap_var` is 0, an overflowing operation with `wr_en` = 1 still commits its digit carries.
- R10: A clock edge with `rst_n` = 0 clears `digit_cb` to all zeros.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| opnd_a | input | 32 | First operand |
| opnd_b | input | 32 | Second operand (inverted for subtract) |
| sub_sel | input | 1 | 0 = add, 1 = subtract |
| carry_in | input | 1 | Carry into digit 0 |
| trap_var | input | 1 | Operation is the trapping variant |
| wr_en | input | 1 | Request to write the digit vector |
| result | output | 32 | Sum or difference |
| ovf | output | 1 | Signed overflow |
| trap_req | output | 1 | Overflow trap request |
| digit_cb | output | 8 | Registered per-digit carry/no-borrow vector |

## Verification
The bench builds the block with its default parameters: a 32-bit datapath split into 4-bit digits, which gives eight status bits. At full width, carries can ripple through all eight digit adders, for example 0xFFFFFFFF + 1. Signed overflow at bit 31 can be reached from both add and subtract, so the trap suppression of the vector and its commit on the non-trapping path can both be driven to their edges.

// File: rtl/cb_pkg.sv
// Shared types for the per-digit carry/borrow adder.
// Assumes nothing beyond the operation encoding below.
package cb_pkg;
    typedef enum logic {
        OP_ADD = 1'b0,
        OP_SUB = 1'b1
    } cb_op_e;
endpackage

// File: rtl/cb_digit_add.sv
// One digit slice: adds two W-bit digits and a carry-in.
// Produces the digit sum and the carry that leaves the digit.
// Assumes the caller has already inverted the second operand for a subtract.
module cb_digit_add #(
    parameter int W = 4
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         cin,
    output logic [W-1:0] sum,
    output logic         cout
);
    // Widened add: the top bit is the carry out of the digit
    always_comb begin
        {cout, sum} = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, cin};
    end
endmodule

// File: rtl/cb_ovf_detect.sv
// Signed overflow from the most significant bit position.
// Recovers the carry into the MSB from the operand and sum bits, then
// compares it with the carry out of the MSB.
module cb_ovf_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic a_msb,
    input  logic b_msb,
    input  logic s_msb,
    input  logic cout,
    output logic ovf
);
    logic carry_into_msb;

    // Carry into MSB, then compare it with the carry out of MSB
    always_comb begin
        carry_into_msb = a_msb ^ b_msb ^ s_msb;
        ovf            = carry_into_msb ^ cout;
    end

    // R5
    sign_rule_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovf |-> ((a_msb == b_msb) && (s_msb != a_msb)));
endmodule

// File: rtl/cb_status_reg.sv
// Holds the per-digit carry vector.
// It loads only when a write is requested and no trap is raised.
// Assumes next_bits and trap_req are stable before the clock edge.
module cb_status_reg #(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic         trap_req,
    input  logic [N-1:0] next_bits,
    output logic [N-1:0] bits
);
    logic commit;

    // Commit rule: the write is requested and the trap does not fire
    always_comb begin
        commit = wr_en && !trap_req;
    end

    // Status register with synchronous active-low reset
    always_ff @(posedge clk) begin
        if (!rst_n)
            bits <= '0;
        else if (commit)
            bits <= next_bits;
    end

    // R8
    no_write_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(bits));

    // R7
    trap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && trap_req) |=> $stable(bits));

    // R3
    commit_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !trap_req) |=> (bits == $past(next_bits)));
endmodule

// File: rtl/cb_digit_adder.sv
// Top of the per-digit carry/borrow adder.
// Builds a ripple chain of digit slices and takes the carry out of every
// slice, which gives an add carry or a subtract no-borrow per digit.
// It flags signed overflow and a trap request, and commits the vector
// through the status register. Assumes DATA_W is a multiple of DIGIT_W.
module cb_digit_adder #(
    parameter int DATA_W  = 32,
    parameter int DIGIT_W = 4
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [DATA_W-1:0]           opnd_a,
    input  logic [DATA_W-1:0]           opnd_b,
    input  logic                        sub_sel,
    input  logic                        carry_in,
    input  logic                        trap_var,
    input  logic                        wr_en,
    output logic [DATA_W-1:0]           result,
    output logic                        ovf,
    output logic                        trap_req,
    output logic [DATA_W/DIGIT_W-1:0]   digit_cb
);
    import cb_pkg::*;

    localparam int NDIG = DATA_W / DIGIT_W;

    cb_op_e            op;
    logic [DATA_W-1:0] b_eff;
    logic [NDIG:0]     chain;
    logic [NDIG-1:0]   carry_vec;

    // Operand conditioning: invert B for subtract
    always_comb begin
        op       = cb_op_e'(sub_sel);
        b_eff    = (op == OP_SUB) ? ~opnd_b : opnd_b;
        chain[0] = carry_in;
    end

    genvar g;
    generate
        for (g = 0; g < NDIG; g++) begin : g_digit
            cb_digit_add #(.W(DIGIT_W)) u_dig (
                .a   (opnd_a[g*DIGIT_W +: DIGIT_W]),
                .b   (b_eff[g*DIGIT_W +: DIGIT_W]),
                .cin (chain[g]),
                .sum (result[g*DIGIT_W +: DIGIT_W]),
                .cout(chain[g+1])
            );
        end
    endgenerate

    // Per-digit carries: bit k is the carry leaving digit k
    always_comb begin
        carry_vec = chain[NDIG:1];
    end

    cb_ovf_detect u_ovf (
        .clk  (clk),
        .rst_n(rst_n),
        .a_msb(opnd_a[DATA_W-1]),
        .b_msb(b_eff[DATA_W-1]),
        .s_msb(result[DATA_W-1]),
        .cout (chain[NDIG]),
        .ovf  (ovf)
    );

    // Trap request for the trapping variant
    always_comb begin
        trap_req = trap_var && ovf;
    end

    cb_status_reg #(.N(NDIG)) u_stat (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .trap_req (trap_req),
        .next_bits(carry_vec),
        .bits     (digit_cb)
    );

    // R1 R2: the digit chain matches one wide add
    chain_sum_chk: assert property (@(posedge clk) disable iff (!rst_n)
        {chain[NDIG], result} ==
        ({1'b0, opnd_a} + {1'b0, b_eff} + {{DATA_W{1'b0}}, carry_in}));

    // R6
    trap_ovf_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trap_req |-> (ovf && trap_var));
endmodule

// File: tb/cb_digit_adder_bench.sv
module cb_digit_adder_bench;
    localparam int CLK_PERIOD = 10;
    localparam int DW = 32;
    localparam int ND = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [DW-1:0] opnd_a = '0;
    logic [DW-1:0] opnd_b = '0;
    logic          sub_sel = 1'b0;
    logic          carry_in = 1'b0;
    logic          trap_var = 1'b0;
    logic          wr_en = 1'b0;
    logic [DW-1:0] result;
    logic          ovf;
    logic          trap_req;
    logic [ND-1:0] digit_cb;

    int checks = 0;
    int errors = 0;
    logic [ND-1:0] model_cb = '0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cb_digit_adder u_cb_digit_adder (
        .clk(clk), .rst_n(rst_n), .opnd_a(opnd_a), .opnd_b(opnd_b),
        .sub_sel(sub_sel), .carry_in(carry_in), .trap_var(trap_var),
        .wr_en(wr_en), .result(result), .ovf(ovf), .trap_req(trap_req),
        .digit_cb(digit_cb)
    );

    task automatic check(input string req, input string what,
                         input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Carry leaving digit k, computed from wide partial sums
    function automatic logic [ND-1:0] exp_digits(logic [DW-1:0] a,
                                                 logic [DW-1:0] be, logic ci);
        logic [ND-1:0] v;
        for (int k = 0; k < ND; k++) begin
            logic [DW:0] mask;
            logic [DW:0] part;
            mask = (({{DW{1'b0}}, 1'b1}) << (4*k+4)) - 1;
            part = ({1'b0, a} & mask) + ({1'b0, be} & mask) + {{DW{1'b0}}, ci};
            v[k] = part[4*k+4];
        end
        return v;
    endfunction

    task automatic run_op(input logic [DW-1:0] a, input logic [DW-1:0] b,
                          input logic sub, input logic ci,
                          input logic trp, input logic we);
        logic [DW-1:0] be;
        logic [DW-1:0] er;
        logic          eo;
        logic [ND-1:0] ed;
        string         cb_tag;
        @(negedge clk);
        opnd_a = a; opnd_b = b; sub_sel = sub; carry_in = ci;
        trap_var = trp; wr_en = we;
        be = sub ? ~b : b;
        er = a + be + {{(DW-1){1'b0}}, ci};
        eo = (a[DW-1] == be[DW-1]) && (er[DW-1] != a[DW-1]);
        ed = exp_digits(a, be, ci);
        #1;
        check(sub ? "R2" : "R1", "result", result, er);
        check("R5", "ovf", {31'b0, ovf}, {31'b0, eo});
        check("R6", "trap_req", {31'b0, trap_req}, {31'b0, trp && eo});
        if (!we)                cb_tag = "R8";
        else if (trp && eo)     cb_tag = "R7";
        else if (eo)            cb_tag = "R9";
        else if (sub)           cb_tag = "R4";
        else                    cb_tag = "R3";
        if (we && !(trp && eo)) model_cb = ed;
        @(negedge clk);
        wr_en = 1'b0;
        #1;
        check(cb_tag, "digit_cb", {24'b0, digit_cb}, {24'b0, model_cb});
    endtask

    task automatic t_reset();
        run_op(32'h0000_000F, 32'h0000_0001, 1'b0, 1'b0, 1'b0, 1'b1);
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        #1;
        model_cb = '0;
        check("R10", "digit_cb after reset", {24'b0, digit_cb}, 32'h0);
        rst_n = 1'b1;
    endtask

    task automatic t_add();
        run_op(32'h0000_000F, 32'h0000_0001, 1'b0, 1'b0, 1'b0, 1'b1); // R3
        run_op(32'hFFFF_FFFF, 32'h0000_0001, 1'b0, 1'b0, 1'b0, 1'b1); // R3
        run_op(32'h1234_5678, 32'h8765_4321, 1'b0, 1'b1, 1'b0, 1'b1); // R1
        run_op(32'h0F0F_0F0F, 32'h0101_0101, 1'b0, 1'b0, 1'b1, 1'b1); // R3
    endtask

    task automatic t_sub();
        run_op(32'h0000_0010, 32'h0000_0001, 1'b1, 1'b1, 1'b0, 1'b1); // R4
        run_op(32'h0000_0000, 32'h0000_0001, 1'b1, 1'b1, 1'b0, 1'b1); // R4
        run_op(32'h5555_5555, 32'h5555_5555, 1'b1, 1'b1, 1'b1, 1'b1); // R2
        run_op(32'h1000_0000, 32'h0000_0001, 1'b1, 1'b0, 1'b0, 1'b1); // R2
    endtask

    task automatic t_trap();
        run_op(32'h7FFF_FFFF, 32'h0000_0001, 1'b0, 1'b0, 1'b1, 1'b1); // R7
        run_op(32'h8000_0000, 32'h0000_0001, 1'b1, 1'b1, 1'b1, 1'b1); // R7
    endtask

    task automatic t_nontrap_ovf();
        run_op(32'h7FFF_FFFF, 32'h7FFF_FFFF, 1'b0, 1'b0, 1'b0, 1'b1); // R9
        run_op(32'h8000_0000, 32'h7FFF_FFFF, 1'b1, 1'b1, 1'b0, 1'b1); // R9
    endtask

    task automatic t_no_write();
        run_op(32'h0000_0000, 32'h0000_0000, 1'b0, 1'b0, 1'b0, 1'b1);
        run_op(32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0, 1'b1, 1'b0, 1'b0); // R8
        run_op(32'h8888_8888, 32'h8888_8888, 1'b0, 1'b0, 1'b0, 1'b0); // R8
    endtask

    initial begin
        repeat (3) @(negedge clk);
        #1;
        check("R10", "digit_cb at reset", {24'b0, digit_cb}, 32'h0);
        rst_n = 1'b1;
        t_add();
        t_sub();
        t_trap();
        t_nontrap_ovf();
        t_no_write();
        t_reset();
        t_add();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule